// File: doc/BRIEF.md
# Output Port Buffer Arbiter

This block decides, once per scheduling slot, which of the internal buffers feeding one switch output port may send its head cell. Each buffer collects the cells of one group of inputs and is a FIFO, so only its oldest cell can leave. The arbiter sees one occupancy count per buffer and chooses at most one buffer per slot. Storage, cell data and the input side are handled elsewhere.

A two-bit mode input chooses one of three policies. Plain round robin visits the buffers in a fixed cycle and lets a slot go unused when the visited buffer is empty. Work-conserving round robin scans onward from the pointer to the first non-empty buffer. Longest-queue-first serves the fullest buffer, and a tie goes to the buffer nearest the pointer. The decision is registered. It appears as a one-hot select, a valid flag and a binary index in the cycle after the slot strobe.

Top module: `egress_queue_arbiter`

## Requirements
- R1: After reset, grant_valid is 0, grant_onehot is all zeros, grant_idx is 0 and the internal pointer is at buffer 0.
- R2: A decision is made only in a cycle where slot_go is 1. The result is presented in the next cycle for exactly one cycle. In every other cycle grant_valid is 0 and grant_onehot and grant_idx are zero.
- R3: When grant_valid is 1, grant_onehot has exactly the bit grant_idx set, and the chosen buffer held a non-zero occupancy in the slot cycle. grant_onehot never has more than one bit set.
- R4: Mode 2'b00 (plain round robin) visits only the pointer buffer. It grants that buffer if its occupancy is non-zero and grants nothing otherwise. The pointer advances by one, modulo the buffer count, on every slot, including slots where all buffers are empty.
- R5: Mode 2'b01 (work-conserving round robin) grants the first non-empty buffer found by scanning from the pointer upward with wrap-around. The pointer then moves to one past the granted buffer.
- R6: In mode 2'b01, a slot in which any buffer is non-empty always produces a grant.
- R7: Modes 2'b10 and 2'b11 (longest-queue-first) grant the buffer with the largest occupancy. Among equal maxima, the first one met scanning from the pointer with wrap-around wins. The pointer then moves to one past the winner.
- R8: In modes other than 2'b00, a slot in which all buffers are empty grants nothing and leaves the pointer unchanged.
- R9: Occupancy for buffer i is an unsigned 5-bit field at bits [i*5 +: 5] of occ_in. The full range 0 to 31 is compared correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_go | input | 1 | Scheduling slot strobe |
| mode | input | 2 | Policy: 00 round robin, 01 work-conserving, 1x longest-queue-first |
| occ_in | input | NQ*OCC_W | Packed per-buffer occupancy counts, buffer 0 in the low bits |
| grant_onehot | output | NQ | One-hot select of the served buffer |
| grant_valid | output | 1 | A cell is sent in this slot result |
| grant_idx | output | $clog2(NQ) | Index of the served buffer |

## Verification
Plain round robin is run over a mix of full and empty buffers, and once with all buffers empty. A lost slot, and a pointer that keeps moving with nothing to send, separate it from the work-conserving mode. The work-conserving mode is given a single busy buffer far from the pointer, a wrap-around case and an all-empty slot, which show the skip, the scan order and the pointer hold. Longest-queue-first is given equal maxima from two pointer positions, which exposes the tie rule, and the values 31 against 30, which exposes a truncated compare. Strobe-free cycles with full buffers confirm that no grant appears without a slot.

// File: rtl/egress_queue_arbiter.sv
module egress_queue_arbiter #(
  parameter int NQ    = 3,
  parameter int OCC_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slot_go,
  input  logic [1:0]            mode,
  input  logic [NQ*OCC_W-1:0]   occ_in,
  output logic [NQ-1:0]         grant_onehot,
  output logic                  grant_valid,
  output logic [$clog2(NQ)-1:0] grant_idx
);
  localparam int IDX_W = $clog2(NQ);
  localparam logic [1:0] M_RR = 2'b00;
  localparam logic [1:0] M_WC = 2'b01;

  logic [OCC_W-1:0] occ_a [NQ];
  logic [NQ-1:0]    busy;
  logic [IDX_W-1:0] ptr;

  for (genvar g = 0; g < NQ; g++) begin : g_unpack
    assign occ_a[g] = occ_in[g*OCC_W +: OCC_W];
    assign busy[g]  = |occ_a[g];
  end

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] x);
    return (int'(x) == NQ-1) ? '0 : x + 1'b1;
  endfunction

  logic             wc_hit, lq_hit, sel_hit;
  logic [IDX_W-1:0] wc_pick, lq_pick, sel_pick;
  logic [OCC_W-1:0] lq_best;
  int               cand;

  always_comb begin
    wc_hit  = 1'b0;
    wc_pick = ptr;
    lq_hit  = 1'b0;
    lq_pick = ptr;
    lq_best = '0;
    cand    = 0;
    for (int k = 0; k < NQ; k++) begin
      cand = int'(ptr) + k;
      if (cand >= NQ) cand = cand - NQ;
      if (!wc_hit && busy[IDX_W'(cand)]) begin
        wc_hit  = 1'b1;
        wc_pick = IDX_W'(cand);
      end
      if (occ_a[IDX_W'(cand)] > lq_best) begin
        lq_best = occ_a[IDX_W'(cand)];
        lq_pick = IDX_W'(cand);
        lq_hit  = 1'b1;
      end
    end
  end

  always_comb begin
    case (mode)
      M_RR:    begin sel_hit = busy[ptr]; sel_pick = ptr;     end
      M_WC:    begin sel_hit = wc_hit;    sel_pick = wc_pick; end
      default: begin sel_hit = lq_hit;    sel_pick = lq_pick; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr          <= '0;
      grant_valid  <= 1'b0;
      grant_onehot <= '0;
      grant_idx    <= '0;
    end else begin
      grant_valid  <= slot_go && sel_hit;
      grant_onehot <= (slot_go && sel_hit) ? (NQ'(1) << sel_pick) : '0;
      grant_idx    <= (slot_go && sel_hit) ? sel_pick : '0;
      if (slot_go) begin
        if (mode == M_RR)  ptr <= step(ptr);
        else if (sel_hit)  ptr <= step(sel_pick);
      end
    end
  end

  // R2
  valid_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> $past(slot_go));
  // R3
  onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_onehot) && (grant_valid == (grant_onehot != '0)));
  // R3
  nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ((($past(occ_in) >> (int'(grant_idx) * OCC_W)) & {OCC_W{1'b1}}) != '0));
  // R4
  rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_go && mode == M_RR) |=> (ptr == step($past(ptr))));
  // R6
  wc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_go && mode == M_WC && busy != '0) |=> grant_valid);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_go && mode != M_RR && busy == '0) |=> (!grant_valid && ptr == $past(ptr)));
endmodule

// File: tb/egress_queue_arbiter_test.sv
module egress_queue_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slot_go = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [14:0] occ_in = '0;
  logic [2:0] grant_onehot;
  logic       grant_valid;
  logic [1:0] grant_idx;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  egress_queue_arbiter uut (
    .clk(clk), .rst_n(rst_n), .slot_go(slot_go), .mode(mode), .occ_in(occ_in),
    .grant_onehot(grant_onehot), .grant_valid(grant_valid), .grant_idx(grant_idx));

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; slot_go = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  // one slot; result is checked in the following cycle, then the pulse end
  task automatic do_slot(input string req, input logic [1:0] m,
                         input int o0, input int o1, input int o2,
                         input bit ev, input int ei);
    @(negedge clk);
    mode = m; occ_in = {5'(o2), 5'(o1), 5'(o0)}; slot_go = 1'b1;
    @(negedge clk);
    slot_go = 1'b0;
    chk(req, "valid", int'(grant_valid), int'(ev));
    chk(req, "idx", int'(grant_idx), ev ? ei : 0);
    chk(req, "onehot", int'(grant_onehot), ev ? (1 << ei) : 0);
    @(negedge clk);
    chk("R2", "pulse end", int'(grant_valid), 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "valid", int'(grant_valid), 0);
    chk("R1", "onehot", int'(grant_onehot), 0);
    chk("R1", "idx", int'(grant_idx), 0);
    do_slot("R1", 2'b00, 1, 1, 1, 1'b1, 0);
  endtask

  task automatic t_noslot();
    do_reset();
    @(negedge clk); mode = 2'b01; occ_in = {5'd7, 5'd7, 5'd7};
    repeat (3) begin
      @(negedge clk);
      chk("R2", "no strobe valid", int'(grant_valid), 0);
      chk("R2", "no strobe onehot", int'(grant_onehot), 0);
    end
  endtask

  task automatic t_rr();
    do_reset();
    do_slot("R4", 2'b00, 3, 0, 2, 1'b1, 0);
    do_slot("R4", 2'b00, 3, 0, 2, 1'b0, 0);
    do_slot("R4", 2'b00, 3, 0, 2, 1'b1, 2);
    do_slot("R4", 2'b00, 0, 0, 0, 1'b0, 0);
    do_slot("R4", 2'b00, 1, 1, 1, 1'b1, 1);
  endtask

  task automatic t_wc();
    do_reset();
    do_slot("R5", 2'b01, 0, 0, 4, 1'b1, 2);
    do_slot("R5", 2'b01, 5, 5, 5, 1'b1, 0);
    do_slot("R8", 2'b01, 0, 0, 0, 1'b0, 0);
    do_slot("R8", 2'b01, 1, 1, 1, 1'b1, 1);
    do_slot("R6", 2'b01, 2, 0, 0, 1'b1, 0);
  endtask

  task automatic t_lqf();
    do_reset();
    do_slot("R7", 2'b10, 3, 9, 9, 1'b1, 1);
    do_slot("R7", 2'b10, 3, 9, 9, 1'b1, 2);
    do_slot("R7", 2'b10, 20, 1, 19, 1'b1, 0);
    do_slot("R8", 2'b10, 0, 0, 0, 1'b0, 0);
    do_slot("R8", 2'b10, 4, 4, 4, 1'b1, 1);
    do_slot("R9", 2'b10, 30, 0, 31, 1'b1, 2);
    do_slot("R7", 2'b11, 1, 7, 2, 1'b1, 1);
  endtask

  initial begin
    t_reset();
    t_noslot();
    t_rr();
    t_wc();
    t_lqf();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule